// File: doc/BRIEF.md
# Flit Check-Code Generator and Checker

This block protects one 80-bit link-layer flit with an 8-bit cyclic check code built on the generator x^8 + x^7 + x^2 + 1. A flit is made of four 20-bit phits. Each phit carries 16 payload bits, 2 control bits and 2 check bits. The 72 information bits are the payload and control bits together. When the block generates, it recomputes the check code from the information bits and writes it into the check positions of the outgoing flit. When it checks, it passes the received flit through unchanged and raises an error flag if the code it recomputes does not match the check bits that arrived.

Flits enter through a valid/ready handshake and leave one clock later from an output register. That register holds its contents until the consumer takes them. A per-flit select input chooses between generating and checking. A separate rolling input chains the codes: while rolling is on, the remainder of each accepted flit becomes the starting value of the register for the next flit. This ties neighbouring flits together. Transmitter and receiver must run the same chain.

Top module: `flit_crc_unit`

## Requirements
- R1: After reset, outValid and outErr are 0, inReady is 1, and the rolling seed is zero.
- R2: inReady is 1 whenever outValid is 0 or outReady is 1. A flit is accepted on a clock edge where inValid and inReady are both 1.
- R3: An accepted flit appears on outFlit with outValid = 1 one clock after it is accepted.
- R4: In generate mode (inCheck = 0), the information bits of outFlit equal those of the input. The check positions hold the code computed from the information bits. The check bits supplied at the input are ignored.
- R5: Layout: phit p occupies flit bits [20p+19:20p]. Within a phit, bits [15:0] are payload, [17:16] are control and [19:18] are check bits. The 72-bit information word is the concatenation of phits 3 down to 0, each contributing {control, payload}. Code bits [2p+1:2p] sit in phit p.
- R6: In check mode (inCheck = 1), outFlit equals the input flit. outErr is 1 exactly when the recomputed code differs from the received check bits, and outErr is only ever 1 while outValid is 1.
- R7: The code is the remainder of seed*x^72 + info*x^8 divided by x^8+x^7+x^2+1, with the information bits taken most significant first. The seed is zero when rolling is off.
- R8: In check mode, every single, double, triple and odd-count bit error is flagged, and so is every burst of up to 8 adjacent codeword bits.
- R9: With rollEn = 1, the seed of each flit is the remainder computed for the previously accepted flit, in either mode.
- R10: Whenever rollEn is 0, the seed is returned to zero. Enabling rolling again starts the chain from a zero seed.
- R11: While outValid = 1 and outReady = 0, outFlit and outErr hold and outValid stays 1.
- R12: outErr is 0 for a flit accepted in generate mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input flit is valid |
| inReady | output | 1 | Block can accept a flit |
| inFlit | input | 80 | Input flit |
| inCheck | input | 1 | 0 = generate check bits, 1 = check received bits |
| rollEn | input | 1 | Rolling chain mode enable |
| outValid | output | 1 | Output flit is valid |
| outReady | input | 1 | Consumer takes the output flit |
| outFlit | output | 80 | Output flit |
| outErr | output | 1 | Check mismatch for the flit on outFlit |

## Verification
Every result is due exactly one clock after the edge that accepts its flit. The bench drives a flit half a period before an edge and reads outFlit, outErr and outValid at the following falling edge, so only the single output register lies between the stimulus and the check. The rolling seed has no port, so the bench observes it through the code of the next accepted flit, one clock later. During a back-pressure stall, the held values are compared at each falling edge until outReady returns.

// File: rtl/flit_crc_pkg.sv
`timescale 1ns/1ps
package flit_crc_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;     // capture a new result into the output register
    logic drop;     // output consumed with no replacement: clear the flag
    logic seedUpd;  // take the fresh remainder as next seed
    logic seedClr;  // return the seed to zero
  } crcStrb_t;

endpackage

// File: rtl/flit_crc_ctrl.sv
`timescale 1ns/1ps
module flit_crc_ctrl
  import flit_crc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     inValid,
  input  logic     outReady,
  input  logic     rollEn,
  output logic     inReady,
  output logic     outValid,
  output crcStrb_t strb
);

  logic accept;

  assign inReady = !outValid || outReady;
  assign accept  = inValid && inReady;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid <= 1'b0;
    end else if (accept) begin
      outValid <= 1'b1;
    end else if (outReady) begin
      outValid <= 1'b0;
    end
  end

  always_comb begin
    strb         = '0;
    strb.load    = accept;
    strb.drop    = outValid && outReady && !accept;
    strb.seedUpd = accept && rollEn;
    strb.seedClr = !rollEn;
  end

endmodule

// File: rtl/flit_crc_dp.sv
`timescale 1ns/1ps
module flit_crc_dp
  import flit_crc_pkg::*;
#(
  parameter int           PHITS = 4,
  parameter int           PAY_W = 16,
  parameter int           CTL_W = 2,
  parameter int           CHK_W = 2,
  parameter logic [7:0]   POLY  = 8'h85,
  localparam int          SEG_W  = PAY_W + CTL_W,
  localparam int          PHIT_W = SEG_W + CHK_W,
  localparam int          FLIT_W = PHITS * PHIT_W,
  localparam int          INFO_W = PHITS * SEG_W,
  localparam int          CRC_W  = PHITS * CHK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  crcStrb_t          strb,
  input  logic [FLIT_W-1:0] inFlit,
  input  logic              inCheck,
  input  logic              rollEn,
  output logic [FLIT_W-1:0] outFlit,
  output logic              outErr
);

  logic [INFO_W-1:0] infoVec;
  logic [CRC_W-1:0]  rxCrc;
  logic [CRC_W-1:0]  calcCrc;
  logic [CRC_W-1:0]  seedReg;
  logic [CRC_W-1:0]  seedVal;
  logic [FLIT_W-1:0] genFlit;

  // Field split and merge, one slice per phit
  for (genvar p = 0; p < PHITS; p++) begin : g_phit
    assign infoVec[p*SEG_W +: SEG_W]  = inFlit[p*PHIT_W +: SEG_W];
    assign rxCrc[p*CHK_W +: CHK_W]    = inFlit[p*PHIT_W + SEG_W +: CHK_W];
    assign genFlit[p*PHIT_W +: PHIT_W] = {calcCrc[p*CHK_W +: CHK_W],
                                          infoVec[p*SEG_W +: SEG_W]};
  end

  assign seedVal = rollEn ? seedReg : '0;

  // Whole-word division, most significant information bit first
  always_comb begin
    logic [CRC_W-1:0] rem;
    logic             fb;
    rem = seedVal;
    for (int i = INFO_W - 1; i >= 0; i--) begin
      fb  = rem[CRC_W-1] ^ infoVec[i];
      rem = {rem[CRC_W-2:0], 1'b0};
      if (fb) rem = rem ^ POLY;
    end
    calcCrc = rem;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outFlit <= '0;
      outErr  <= 1'b0;
    end else if (strb.load) begin
      outFlit <= inCheck ? inFlit : genFlit;
      outErr  <= inCheck && (calcCrc != rxCrc);
    end else if (strb.drop) begin
      outErr  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || strb.seedClr) begin
      seedReg <= '0;
    end else if (strb.seedUpd) begin
      seedReg <= calcCrc;
    end
  end

endmodule

// File: rtl/flit_crc_unit.sv
`timescale 1ns/1ps
module flit_crc_unit
  import flit_crc_pkg::*;
#(
  parameter int         PHITS = 4,
  parameter int         PAY_W = 16,
  parameter int         CTL_W = 2,
  parameter int         CHK_W = 2,
  parameter logic [7:0] POLY  = 8'h85,
  localparam int        FLIT_W = PHITS * (PAY_W + CTL_W + CHK_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  output logic              inReady,
  input  logic [FLIT_W-1:0] inFlit,
  input  logic              inCheck,
  input  logic              rollEn,
  output logic              outValid,
  input  logic              outReady,
  output logic [FLIT_W-1:0] outFlit,
  output logic              outErr
);

  crcStrb_t strb;

  flit_crc_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .outReady (outReady),
    .rollEn   (rollEn),
    .inReady  (inReady),
    .outValid (outValid),
    .strb     (strb)
  );

  flit_crc_dp #(
    .PHITS (PHITS),
    .PAY_W (PAY_W),
    .CTL_W (CTL_W),
    .CHK_W (CHK_W),
    .POLY  (POLY)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strb    (strb),
    .inFlit  (inFlit),
    .inCheck (inCheck),
    .rollEn  (rollEn),
    .outFlit (outFlit),
    .outErr  (outErr)
  );

endmodule

// File: rtl/flit_crc_chk.sv
`timescale 1ns/1ps
module flit_crc_chk #(
  parameter int  PHITS = 4,
  parameter int  PAY_W = 16,
  parameter int  CTL_W = 2,
  parameter int  CHK_W = 2,
  localparam int SEG_W  = PAY_W + CTL_W,
  localparam int PHIT_W = SEG_W + CHK_W,
  localparam int FLIT_W = PHITS * PHIT_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              inValid,
  input logic              inReady,
  input logic [FLIT_W-1:0] inFlit,
  input logic              inCheck,
  input logic              outValid,
  input logic              outReady,
  input logic [FLIT_W-1:0] outFlit,
  input logic              outErr
);

  function automatic logic [FLIT_W-1:0] infoMask();
    logic [FLIT_W-1:0] m;
    m = '0;
    for (int i = 0; i < FLIT_W; i++) m[i] = ((i % PHIT_W) < SEG_W);
    return m;
  endfunction

  localparam logic [FLIT_W-1:0] INFO_MASK = infoMask();

  p_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !outValid |-> inReady);

  p_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && inReady |=> outValid);

  p_gen_info_r4: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && inReady && !inCheck |=> ((outFlit ^ $past(inFlit)) & INFO_MASK) == '0);

  p_check_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && inReady && inCheck |=> outFlit == $past(inFlit));

  p_err_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    outErr |-> outValid);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && !outReady |=> outValid && $stable(outFlit) && $stable(outErr));

  p_gen_clean_r12: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && inReady && !inCheck |=> !outErr);

endmodule

bind flit_crc_unit flit_crc_chk #(
  .PHITS (PHITS),
  .PAY_W (PAY_W),
  .CTL_W (CTL_W),
  .CHK_W (CHK_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .inValid  (inValid),
  .inReady  (inReady),
  .inFlit   (inFlit),
  .inCheck  (inCheck),
  .outValid (outValid),
  .outReady (outReady),
  .outFlit  (outFlit),
  .outErr   (outErr)
);

// File: tb/flit_crc_unit_tb.sv
`timescale 1ns/1ps
module flit_crc_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [79:0] inFlit = '0;
  logic        inCheck = 1'b0;
  logic        rollEn = 1'b0;
  logic        outValid;
  logic        outReady = 1'b1;
  logic [79:0] outFlit;
  logic        outErr;

  int checks = 0;
  int fails  = 0;
  logic [7:0] mSeed = '0;

  always #4 clk = ~clk;

  flit_crc_unit u_dut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inReady(inReady),
    .inFlit(inFlit), .inCheck(inCheck), .rollEn(rollEn),
    .outValid(outValid), .outReady(outReady), .outFlit(outFlit), .outErr(outErr)
  );

  // R7: remainder of (seed*x^72 + info*x^8) mod x^8+x^7+x^2+1
  function automatic logic [7:0] refCrc(input logic [7:0] seed, input logic [71:0] info);
    logic [79:0] v;
    v = {info, 8'h00};
    v[79:72] = v[79:72] ^ seed;
    for (int i = 79; i >= 8; i--)
      if (v[i]) v[i -: 9] = v[i -: 9] ^ 9'h185;
    return v[7:0];
  endfunction

  // R5 layout
  function automatic logic [79:0] pack(input logic [71:0] info, input logic [7:0] crc);
    logic [79:0] f;
    for (int p = 0; p < 4; p++) f[p*20 +: 20] = {crc[2*p +: 2], info[p*18 +: 18]};
    return f;
  endfunction

  function automatic logic [71:0] infoOf(input logic [79:0] f);
    logic [71:0] x;
    for (int p = 0; p < 4; p++) x[p*18 +: 18] = f[p*20 +: 18];
    return x;
  endfunction

  function automatic logic [71:0] rndInfo();
    return {$urandom(), $urandom(), 8'($urandom())};
  endfunction

  task automatic check(input logic ok, input string req, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] effSeed();
    return rollEn ? mSeed : 8'h00;
  endfunction

  // Send one flit, check the result one clock later.
  task automatic sendFlit(input logic [79:0] f, input logic chk, input string req);
    logic [7:0]  c;
    logic [79:0] expF;
    logic        expE;
    c    = refCrc(effSeed(), infoOf(f));
    expF = chk ? f : pack(infoOf(f), c);
    expE = chk && (c != {f[79:78], f[59:58], f[39:38], f[19:18]});
    @(negedge clk);
    inValid = 1'b1; inFlit = f; inCheck = chk;
    #1 check(inReady == 1'b1, {req, " R2 ready"}, 80'(inReady), 80'd1);
    @(negedge clk);
    inValid = 1'b0;
    if (rollEn) mSeed = c; else mSeed = 8'h00;
    check(outValid == 1'b1, {req, " R3 valid"}, 80'(outValid), 80'd1);
    check(outFlit == expF, {req, " flit"}, outFlit, expF);
    check(outErr == expE, {req, " err"}, 80'(outErr), 80'(expE));
  endtask

  function automatic logic [79:0] goodFlit(input logic [71:0] info, input logic [7:0] seed);
    return pack(info, refCrc(seed, info));
  endfunction

  // Flip codeword bits given as a mask over {info, crc}
  function automatic logic [79:0] corrupt(input logic [79:0] f, input logic [79:0] cwMask);
    logic [79:0] cw;
    cw = {infoOf(f), f[79:78], f[59:58], f[39:38], f[19:18]} ^ cwMask;
    return pack(cw[79:8], cw[7:0]);
  endfunction

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [71:0] info;
    logic [79:0] f, held;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(outValid == 1'b0, "R1 outValid", 80'(outValid), 80'd0);
    check(outErr == 1'b0, "R1 outErr", 80'(outErr), 80'd0);
    check(inReady == 1'b1, "R1 inReady", 80'(inReady), 80'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0, "R1 idle after reset", 80'(outValid), 80'd0);

    // R4 R7 R12: all-zero and all-one information, garbage in check slots
    sendFlit(80'h0, 1'b0, "R4 zero");
    sendFlit({4{20'hC_0000}}, 1'b0, "R4 ignore slots");
    sendFlit({4{20'h3_FFFF}}, 1'b0, "R7 ones");
    for (int k = 0; k < 20; k++)
      sendFlit(pack(rndInfo(), 8'($urandom())), 1'b0, "R4 R12 random gen");

    // R6 good flits pass clean
    for (int k = 0; k < 10; k++)
      sendFlit(goodFlit(rndInfo(), 8'h00), 1'b1, "R6 clean check");

    // R8 single, double, triple, odd-count and burst errors
    for (int k = 0; k < 40; k++) begin
      logic [79:0] m;
      int a, b;
      f = goodFlit(rndInfo(), 8'h00);
      a = $urandom_range(79, 0);
      b = $urandom_range(79, 0);
      case (k % 5)
        0: m = 80'd1 << a;
        1: m = (80'd1 << a) | (80'd1 << ((a + 1 + b % 79) % 80));
        2: m = (80'd1 << (a % 78)) | (80'd1 << (a % 78 + 1)) | (80'd1 << 79);
        3: m = 80'h1F << (a % 75);
        default: m = ((80'hFF >> (b % 7)) | 80'h81) << (a % 72) & (80'hFF << (a % 72));
      endcase
      if (m == '0) m = 80'd1;
      sendFlit(corrupt(f, m), 1'b1, "R8 injected error");
      check(u_dut.outErr == 1'b1, "R8 flagged", 80'(outErr), 80'd1);
    end

    // R9 rolling chain in generate mode then check mode
    @(negedge clk); rollEn = 1'b1;
    for (int k = 0; k < 6; k++)
      sendFlit(pack(rndInfo(), 8'h00), 1'b0, "R9 rolling gen");
    for (int k = 0; k < 4; k++) begin
      info = rndInfo();
      sendFlit(goodFlit(info, mSeed), 1'b1, "R9 rolling check");
    end
    // a flit with a zero-seed code must mismatch while chained (seed nonzero)
    info = rndInfo();
    if (mSeed != 8'h00) begin
      sendFlit(goodFlit(info, 8'h00), 1'b1, "R9 stale seed");
      check(outErr == 1'b1, "R9 stale seed flagged", 80'(outErr), 80'd1);
    end

    // R10 rolling off clears, then on again starts at zero
    @(negedge clk); rollEn = 1'b0; mSeed = 8'h00;
    @(negedge clk); rollEn = 1'b1;
    info = rndInfo();
    sendFlit(pack(info, 8'h00), 1'b0, "R10 restart");
    check(outFlit == goodFlit(info, 8'h00), "R10 zero seed", outFlit, goodFlit(info, 8'h00));
    @(negedge clk); rollEn = 1'b0; mSeed = 8'h00;

    // R11 back-pressure hold
    outReady = 1'b0;
    info = rndInfo();
    sendFlit(pack(info, 8'h00), 1'b0, "R11 first");
    held = outFlit;
    inValid = 1'b1; inFlit = pack(rndInfo(), 8'h00); inCheck = 1'b0;
    for (int k = 0; k < 3; k++) begin
      #1 check(inReady == 1'b0, "R2 stalled ready", 80'(inReady), 80'd0);
      @(negedge clk);
      check(outValid == 1'b1 && outFlit == held, "R11 held", outFlit, held);
    end
    outReady = 1'b1;
    f = inFlit;
    @(negedge clk);
    inValid = 1'b0;
    check(outFlit == goodFlit(infoOf(f), 8'h00), "R11 next after release", outFlit, goodFlit(infoOf(f), 8'h00));
    @(negedge clk);
    check(outValid == 1'b0 && outErr == 1'b0, "R3 drained", 80'(outValid), 80'd0);

    // mixed random traffic
    for (int k = 0; k < 60; k++) begin
      @(negedge clk); rollEn = $urandom_range(1, 0);
      if (!rollEn) mSeed = 8'h00;
      info = rndInfo();
      f = goodFlit(info, effSeed());
      if ($urandom_range(1, 0)) f = corrupt(f, 80'd1 << $urandom_range(79, 0));
      sendFlit(f, 1'($urandom_range(1, 0)), "R6 R9 mixed");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule